// File: doc/BRIEF.md
# Cross-Coupled Adaptive Two-Channel Separator

This block takes a pair of mixed audio samples, one from each of two microphones, and produces a pair of separated samples. Each channel has its own least-mean-squares filter. That filter estimates the crosstalk leaking into its channel from the recent separated outputs of the other channel. The filter subtracts the estimate from its microphone sample, and the difference becomes the channel output. The filter then adjusts its weights by the product of that output and its regressor. The feedback between the two channels makes the pair adapt together and symmetrically.

A sample pair is accepted on a strobe. Both filters then share one tap counter and run in lockstep. First a serial multiply-accumulate pass over all taps runs in parallel in both channels. One cycle then forms the outputs. A second serial pass updates the weights. In the last step each output is pushed into its own history, the outputs are published and a valid pulse is raised. The whole pass takes about twice the tap count in cycles, which fits easily inside an audio sample period at a clock in the tens of MHz. A bypass input routes the microphone samples straight to the outputs and leaves the adaptive state untouched.

Top module: `xlms_sep`

## Requirements
- R1: A synchronous active-high reset sets both outputs to 0, sets `out_vld` to 0, and clears all weights and both output histories to 0. The first adaptive sample after any reset therefore returns each microphone sample unchanged.
- R2: For an adaptive sample, `out_a = sat(mic_a - sat(rnd13(sum_i wa[i]*hb[i])))`. `hb[i]` is channel B's output from i+1 samples earlier, and its entries are 0 when no such sample exists. Products are exact and summed in a wide accumulator. `rnd13` adds 2^12 and then shifts arithmetically right by 13.
- R3: Channel B is the mirror image of channel A: `out_b = sat(mic_b - sat(rnd13(sum_i wb[i]*ha[i])))`, with `ha` holding channel A's past outputs.
- R4: After the outputs of a sample are formed, every weight is updated as `w[i] = sat(w[i] + sat(rnd26(2*MU*e*x[i])))`. Here `e` is that channel's new output, `x[i]` is the regressor entry before the new outputs are shifted in, and `rnd26` adds 2^25 and then shifts right by 26.
- R5: Each history keeps the N most recent outputs of its own channel. Index 0 holds the newest entry. A new sample enters at index 0 only after the weight update, and the entry at index N-1 is dropped.
- R6: All samples, weights and outputs are 16-bit two's-complement Q3.13. Any result that goes out of range is clamped to 32767 or to -32768 and never wraps.
- R7: A strobe accepted while `bypass` is 1 makes `out_a`/`out_b` equal `mic_a`/`mic_b`, with `out_vld` high one cycle after the strobe edge. Weights and histories are left unchanged.
- R8: `out_vld` is a single-cycle pulse. For an adaptive sample it rises exactly 2N+2 clock edges after the edge that accepted the strobe. The outputs hold their value between pulses.
- R9: A strobe that arrives while a sample is still being processed is ignored. It produces no extra valid pulse and has no effect on the results.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe that presents a new sample pair |
| bypass | input | 1 | Sampled with the strobe; 1 passes the microphones straight through |
| mic_a | input | 16 | Microphone A sample, Q3.13 |
| mic_b | input | 16 | Microphone B sample, Q3.13 |
| out_a | output | 16 | Separated channel A, Q3.13 |
| out_b | output | 16 | Separated channel B, Q3.13 |
| out_vld | output | 1 | Pulse marking that both outputs are new |

## Verification
The bench compares every output against a bit-exact arithmetic model under two regimes. With small amplitudes the values stay in range. With full-scale inputs and a large step, weights and outputs reach the rails, so a design that wraps instead of clamping produces outputs with the wrong sign. Long sequences expose a regressor taken from the wrong channel, one shifted before the update instead of after it, or rounding by truncation, because each of these makes outputs drift from the model after a few samples. The bench also checks the following: a bypass sample inserted in mid-sequence, which must not disturb the adaptive state; a second strobe arriving mid-pass, which a careless controller would restart on; and a reset during a pass, which must leave zero weights behind.

// File: rtl/xlms_pkg.sv
package xlms_pkg;

    localparam int QW = 16;
    localparam int QF = 13;

    typedef logic signed [QW-1:0] q_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MAC,
        PH_ERR,
        PH_UPD,
        PH_PUSH
    } phase_e;

    // widen a Q3.13 value to 64 signed bits
    function automatic logic signed [63:0] ext64(input q_t v);
        return {{(64-QW){v[QW-1]}}, v};
    endfunction

    // clamp a wide value into the 16-bit signed range
    function automatic q_t sat_q(input logic signed [63:0] v);
        if (v > 64'sd32767)
            return 16'sh7FFF;
        else if (v < -64'sd32768)
            return 16'sh8000;
        else
            return v[QW-1:0];
    endfunction

    // round half up, then arithmetic shift right
    function automatic logic signed [63:0] rnd_shr(input logic signed [63:0] v, input int sh);
        logic signed [63:0] half;
        half = 64'sd1 <<< (sh - 1);
        return (v + half) >>> sh;
    endfunction

endpackage

// File: rtl/xlms_hist.sv
module xlms_hist
    import xlms_pkg::*;
#(
    parameter int N     = 100,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  q_t               din,
    input  logic [IDX_W-1:0] idx,
    output q_t               tap
);

    q_t h [N];

    assign tap = h[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) h[i] <= '0;
        end else if (push) begin
            h[0] <= din;
            for (int i = 1; i < N; i++) h[i] <= h[i-1];
        end
    end

endmodule

// File: rtl/xlms_tap.sv
module xlms_tap
    import xlms_pkg::*;
#(
    parameter int N     = 100,
    parameter int MU    = 1,
    parameter int ACC_W = 48,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             mac_en,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] idx,
    input  q_t               x_in,
    input  q_t               err_in,
    output q_t               est
);

    localparam logic signed [63:0] STEP2 = 64'(2 * MU);

    q_t                      w [N];
    logic signed [ACC_W-1:0] acc;
    q_t                      w_sel;
    logic signed [63:0]      prod64;
    logic signed [63:0]      acc64;
    logic signed [63:0]      scl64;
    q_t                      delta;
    q_t                      w_nxt;

    assign w_sel  = w[idx];
    assign prod64 = ext64(w_sel) * ext64(x_in);
    assign acc64  = {{(64-ACC_W){acc[ACC_W-1]}}, acc};
    assign est    = sat_q(rnd_shr(acc64, QF));

    assign scl64  = ext64(err_in) * ext64(x_in) * STEP2;
    assign delta  = sat_q(rnd_shr(scl64, 2 * QF));
    assign w_nxt  = sat_q(ext64(w_sel) + ext64(delta));

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (mac_en)
            acc <= acc + prod64[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) w[i] <= '0;
        end else if (upd_en) begin
            w[idx] <= w_nxt;
        end
    end

endmodule

// File: rtl/xlms_sep.sv
module xlms_sep
    import xlms_pkg::*;
#(
    parameter int N     = 100,
    parameter int MU    = 1,
    parameter int ACC_W = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_stb,
    input  logic        bypass,
    input  logic [15:0] mic_a,
    input  logic [15:0] mic_b,
    output logic [15:0] out_a,
    output logic [15:0] out_b,
    output logic        out_vld
);

    localparam int               IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N - 1);

    phase_e           st;
    logic [IDX_W-1:0] idx;
    q_t               mic_q [2];
    q_t               err_q [2];
    q_t               err_d [2];
    q_t               est_w [2];
    q_t               tap_w [2];
    logic             start;

    assign start = (st == PH_IDLE) && smp_stb && !bypass;

    // one filter and one output history per channel; each filter reads the other channel's history
    for (genvar c = 0; c < 2; c++) begin : g_ch
        xlms_tap #(.N(N), .MU(MU), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_tap (
            .clk    (clk),
            .rst    (rst),
            .clr    (start),
            .mac_en (st == PH_MAC),
            .upd_en (st == PH_UPD),
            .idx    (idx),
            .x_in   (tap_w[1-c]),
            .err_in (err_q[c]),
            .est    (est_w[c])
        );

        xlms_hist #(.N(N), .IDX_W(IDX_W)) u_hist (
            .clk  (clk),
            .rst  (rst),
            .push (st == PH_PUSH),
            .din  (err_q[c]),
            .idx  (idx),
            .tap  (tap_w[c])
        );

        assign err_d[c] = sat_q(ext64(mic_q[c]) - ext64(est_w[c]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PH_IDLE;
            idx     <= '0;
            out_a   <= '0;
            out_b   <= '0;
            out_vld <= 1'b0;
            for (int c = 0; c < 2; c++) begin
                mic_q[c] <= '0;
                err_q[c] <= '0;
            end
        end else begin
            out_vld <= 1'b0;
            case (st)
                PH_IDLE: begin
                    if (smp_stb) begin
                        if (bypass) begin
                            out_a   <= mic_a;
                            out_b   <= mic_b;
                            out_vld <= 1'b1;
                        end else begin
                            mic_q[0] <= mic_a;
                            mic_q[1] <= mic_b;
                            idx      <= '0;
                            st       <= PH_MAC;
                        end
                    end
                end
                PH_MAC: begin
                    if (idx == LAST) begin
                        idx <= '0;
                        st  <= PH_ERR;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_ERR: begin
                    err_q[0] <= err_d[0];
                    err_q[1] <= err_d[1];
                    st       <= PH_UPD;
                end
                PH_UPD: begin
                    if (idx == LAST) begin
                        idx <= '0;
                        st  <= PH_PUSH;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_PUSH: begin
                    out_a   <= err_q[0];
                    out_b   <= err_q[1];
                    out_vld <= 1'b1;
                    st      <= PH_IDLE;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlms_sep_chk.sv
module xlms_sep_chk
    import xlms_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        smp_stb,
    input logic        bypass,
    input logic [15:0] mic_a,
    input logic [15:0] mic_b,
    input logic [15:0] out_a,
    input logic [15:0] out_b,
    input logic        out_vld,
    input phase_e      st
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: one edge after a reset edge the outputs are cleared
    always @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (out_vld == 1'b0 && out_a == 16'd0 && out_b == 16'd0)
                else $error("R1 outputs not cleared by reset");
        end
    end

    // R7: bypass strobe in idle gives the microphone samples one edge later
    a_r7_bypass_pass: assert property (@(posedge clk) disable iff (rst)
        (st == PH_IDLE && smp_stb && bypass) |=>
            (out_vld && out_a == $past(mic_a) && out_b == $past(mic_b)));

    // R8: no valid pulse while a sample is in flight
    a_r8_quiet_busy: assert property (@(posedge clk) disable iff (rst)
        (st != PH_IDLE) |-> !out_vld);

    // R8: outputs hold between valid pulses
    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(out_a) && $stable(out_b)));

    // R9: a strobe during processing never returns the controller to idle early
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        ((st == PH_MAC || st == PH_ERR || st == PH_UPD) && smp_stb) |=> (st != PH_IDLE));

    // R8: a valid pulse comes only from the publish step or an idle bypass
    a_r8_vld_source: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($past(st) == PH_PUSH ||
                     ($past(st) == PH_IDLE && $past(smp_stb) && $past(bypass))));

endmodule

bind xlms_sep xlms_sep_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .smp_stb (smp_stb),
    .bypass  (bypass),
    .mic_a   (mic_a),
    .mic_b   (mic_b),
    .out_a   (out_a),
    .out_b   (out_b),
    .out_vld (out_vld),
    .st      (st)
);

// File: tb/xlms_sep_tb_top.sv
`timescale 1ns/1ps
module xlms_sep_tb_top;

    localparam int N  = 4;
    localparam int MU = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic        bypass = 1'b0;
    logic [15:0] mic_a = '0;
    logic [15:0] mic_b = '0;
    logic [15:0] out_a;
    logic [15:0] out_b;
    logic        out_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int rails = 0;
    int seed  = 32'h1234_5678;

    longint wa [N];
    longint wb [N];
    longint ha [N];
    longint hb [N];

    always #2.5 clk = ~clk;

    xlms_sep #(.N(N), .MU(MU), .ACC_W(48)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .smp_stb (smp_stb),
        .bypass  (bypass),
        .mic_a   (mic_a),
        .mic_b   (mic_b),
        .out_a   (out_a),
        .out_b   (out_b),
        .out_vld (out_vld)
    );

    function automatic longint sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint rnd(input longint v, input int s);
        return (v + (longint'(1) <<< (s - 1))) >>> s;
    endfunction

    function automatic longint s16(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < N; i++) begin
            wa[i] = 0; wb[i] = 0; ha[i] = 0; hb[i] = 0;
        end
    endtask

    // model of R2..R6: outputs, then update with pre-shift regressors, then shift
    task automatic mdl_step(input longint ma, input longint mb, output longint ea, output longint eb);
        longint acc_a = 0;
        longint acc_b = 0;
        for (int i = 0; i < N; i++) begin
            acc_a += wa[i] * hb[i];
            acc_b += wb[i] * ha[i];
        end
        ea = sat(ma - sat(rnd(acc_a, 13)));
        eb = sat(mb - sat(rnd(acc_b, 13)));
        for (int i = 0; i < N; i++) begin
            wa[i] = sat(wa[i] + sat(rnd(longint'(2 * MU) * ea * hb[i], 26)));
            wb[i] = sat(wb[i] + sat(rnd(longint'(2 * MU) * eb * ha[i], 26)));
        end
        for (int i = N - 1; i > 0; i--) begin
            ha[i] = ha[i-1];
            hb[i] = hb[i-1];
        end
        ha[0] = ea;
        hb[0] = eb;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_clear();
    endtask

    // adaptive sample; inject puts an extra strobe in mid-pass (R9)
    task automatic run_sample(input longint ma, input longint mb, input bit inject);
        longint ea, eb;
        int cnt;
        mdl_step(ma, mb, ea, eb);
        @(negedge clk);
        mic_a = 16'(ma); mic_b = 16'(mb); bypass = 1'b0; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        cnt = 0;
        while (!out_vld && cnt < 1000) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                smp_stb = 1'b1; mic_a = 16'h1000; mic_b = 16'hF000;
            end
            if (inject && cnt == 4) smp_stb = 1'b0;
        end
        chk(cnt == 2 * N + 2, "R8 latency", cnt, 2 * N + 2);
        chk(s16(out_a) == ea, "R2/R4/R5 out_a", s16(out_a), ea);
        chk(s16(out_b) == eb, "R3/R4/R5 out_b", s16(out_b), eb);
        if (ea == 32767 || ea == -32768 || eb == 32767 || eb == -32768) begin
            rails++;
            chk(s16(out_a) == ea && s16(out_b) == eb, "R6 clamp", s16(out_a), ea);
        end
        @(negedge clk);
        chk(out_vld == 1'b0, "R8 pulse width", out_vld, 0);
        if (inject) begin
            // R9: the ignored strobe must not yield another valid pulse
            for (int k = 0; k < 2 * N + 6; k++) begin
                @(negedge clk);
                if (out_vld) chk(1'b0, "R9 extra valid", 1, 0);
            end
            chk(s16(out_a) == ea, "R9 out_a held", s16(out_a), ea);
        end
    endtask

    task automatic run_bypass(input longint ma, input longint mb);
        @(negedge clk);
        mic_a = 16'(ma); mic_b = 16'(mb); bypass = 1'b1; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0; bypass = 1'b0;
        chk(out_vld == 1'b1, "R7 bypass valid", out_vld, 1);
        chk(s16(out_a) == ma, "R7 bypass out_a", s16(out_a), ma);
        chk(s16(out_b) == mb, "R7 bypass out_b", s16(out_b), mb);
        @(negedge clk);
        chk(out_vld == 1'b0, "R8 bypass pulse", out_vld, 0);
    endtask

    function automatic longint lcg(input longint range);
        seed = seed * 1103515245 + 12345;
        return longint'((seed >>> 8) % range);
    endfunction

    initial begin
        longint s1, s2;
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk(out_vld == 1'b0, "R1 vld after reset", out_vld, 0);
        chk(out_a == 16'd0, "R1 out_a after reset", s16(out_a), 0);
        chk(out_b == 16'd0, "R1 out_b after reset", s16(out_b), 0);
        // R1: first sample passes through with zero weights and empty history
        run_sample(3000, -2500, 1'b0);

        // small-amplitude mixtures, two sources cross-leaking
        for (int n = 0; n < 40; n++) begin
            s1 = lcg(8000);
            s2 = lcg(8000);
            run_sample(s1 + s2 / 2, s2 - s1 / 3, 1'b0);
            if (n == 15) run_bypass(-7000, 12345);
            if (n == 25) run_bypass(32767, -32768);
        end

        // R9: strobe arriving mid-pass
        run_sample(5000, -6000, 1'b1);
        run_sample(-1200, 4400, 1'b0);

        // R1: reset during a pass clears the adaptive state
        @(negedge clk);
        mic_a = 16'd9000; mic_b = 16'd100; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();
        @(negedge clk);
        chk(out_a == 16'd0 && out_b == 16'd0, "R1 mid-pass reset", s16(out_a), 0);
        run_sample(-4321, 1234, 1'b0);

        // full-scale inputs drive weights and outputs into clamping (R6)
        for (int n = 0; n < 60; n++) begin
            run_sample(lcg(32768) * ((n % 2) ? 1 : -1), lcg(32768), 1'b0);
        end

        // boundary microphone codes
        run_sample(32767, -32768, 1'b0);
        run_sample(-32768, 32767, 1'b0);
        $display("rail samples seen: %0d", rails);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule